// File: doc/BRIEF.md
# Interrupt and Status Aggregation Unit

This block collects event pulses from the surrounding subsystems of a device into sticky flag registers and drives one active-low interrupt line towards a host. Two register groups exist. The first is an SPI status group: twelve sticky fault bits cover internal access errors, FIFO faults and serial framing faults. A mask register chooses which of those bits count towards an SPI-error summary. The second is an interrupt group: twelve sticky flags cover supply, thermal, watchdog, wake and memory-error events. Two further flags are derived rather than stored. One carries the SPI-error summary and the other follows the line of an embedded controller. An enable register gates part of the interrupt flags onto the output.

Stored bits are cleared by writing one. The derived bits follow their sources and ignore writes. The host reacts to the interrupt by reading the flags and writing back what it saw. It repeats this until the flag register reads zero. The low byte of the flag register is also presented on a separate output, so that a serial front end can return it as a status byte with every transfer.

Top module: `irq_agg_top`

## Requirements
- R1: After a synchronous reset every register reads zero, `irq_n` is 1 and `gstat` is 0.
- R2: A one-cycle pulse on `st_evt[i]` for i in 29..24 or 21..16 sets status bit i until it is cleared. Pulses on any other bit of `st_evt` leave the status register unchanged.
- R3: Writing the status register clears each sticky bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A pulse on `fl_evt[i]` for i in {23,22,21,20,19,18,16,15,14,13,10,8} sets flag bit i until it is cleared, and writing 1 to that bit clears it. Pulses on other bits of `fl_evt` have no effect.
- R5: When an event pulse and a write-one-clear of the same bit fall in the same cycle, the bit stays set.
- R6: The mask register holds bits 29..24 and 21..16 and reads 0 elsewhere. Status bit 1 and flag bit 3 both equal the OR of the status sticky bits whose mask bit is 0. Writing 1 to flag bit 3 or flag bit 1 does not clear them.
- R7: Flag bit 1 follows `ctrl_irq`, delayed by one clock.
- R8: Status bit 2 is the OR of status bits 29..27. Status bit 0 is 1 whenever an interrupt is pending.
- R9: The enable register holds bits 22,21,19,16,15,14,10,8 and reads 0 elsewhere. A flag at one of those positions causes an interrupt only while its enable bit is 1.
- R10: Flags 23, 20, 18, 13, flag 3 and flag 1 cause an interrupt regardless of the enable register.
- R11: `irq_n` is registered. It goes low one clock after an interrupt becomes pending, and it returns high one clock after the last pending cause clears.
- R12: `gstat` is bits 7..0 of the flag register as read, delayed by one clock.
- R13: Register map (byte addresses): status 0x00, mask 0x04, flags 0x08, enable 0x0C. `reg_rdata` shows the register at `reg_addr` one clock later. Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe for the addressed register |
| reg_addr | input | ADDR_W | Byte address for both reads and writes |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| st_evt | input | 32 | Status event pulses, one bit per status position |
| fl_evt | input | 32 | Interrupt event pulses, one bit per flag position |
| ctrl_irq | input | 1 | Embedded controller interrupt level |
| gstat | output | 8 | Global status byte for the serial front end |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The assertions assume that all inputs are synchronous to `clk` and free of X once reset has been released. They also assume that an event is a pulse, so a bit that stays high simply re-sets its flag every cycle. Under these assumptions a flag can only fall in a cycle that carries a host write, and any pending summary or controller line pulls `irq_n` low on the next edge. The stimulus changes inputs only on the falling clock edge. It issues at most one host access per cycle and holds every event line at zero except during deliberate pulses, so these assumptions always hold.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W = 32;

  // status group
  localparam logic [REG_W-1:0] ST_STICKY_MASK   = 32'h3F3F_0000;
  localparam logic [REG_W-1:0] ST_INTERNAL_MASK = 32'h3800_0000;
  localparam int ST_PEND_BIT = 0;
  localparam int ST_SPI_BIT  = 1;
  localparam int ST_INT_BIT  = 2;

  // interrupt flag group
  localparam logic [REG_W-1:0] FL_STICKY_MASK = 32'h00FD_E500;
  localparam logic [REG_W-1:0] FL_GATED_MASK  = 32'h0069_C500;
  localparam logic [REG_W-1:0] FL_NMI_MASK    = FL_STICKY_MASK & ~FL_GATED_MASK;
  localparam int FL_CTRL_BIT   = 1;
  localparam int FL_SPIERR_BIT = 3;

  localparam int GSTAT_W = 8;

  // byte offsets
  localparam int OFF_STATUS  = 'h00;
  localparam int OFF_ERRMASK = 'h04;
  localparam int OFF_FLAGS   = 'h08;
  localparam int OFF_ENABLE  = 'h0C;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_en,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] clr;
  logic [W-1:0] q_r;

  assign clr = clr_en ? clr_data : '0;

  // event set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= ((q_r & ~clr) | evt) & KEEP;
  end

  assign q = q_r;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (!rst && |(evt & KEEP)) |=> ((q & $past(evt & KEEP)) == $past(evt & KEEP))); // R5

  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(q) & ~q & ~$past(clr)) == '0)); // R3
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (wr) q_r <= wdata & KEEP;
  end

  assign q = q_r;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr) |=> $stable(q)); // R9
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       st_evt,
  input  logic [31:0]       fl_evt,
  input  logic              ctrl_irq,
  output logic [7:0]        gstat,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ERRMASK = ADDR_W'(OFF_ERRMASK);
  localparam logic [ADDR_W-1:0] A_FLAGS   = ADDR_W'(OFF_FLAGS);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);

  logic wr_status, wr_mask, wr_flags, wr_enable;
  logic [REG_W-1:0] st_q, mask_q, fl_q, en_q;
  logic [REG_W-1:0] st_view, fl_view, rd_mux;
  logic spi_sum, int_sum, pending, ctrl_q;
  logic [REG_W-1:0] rdata_q;
  logic [GSTAT_W-1:0] gstat_q;
  logic irq_n_q;

  assign wr_status = reg_wr && (reg_addr == A_STATUS);
  assign wr_mask   = reg_wr && (reg_addr == A_ERRMASK);
  assign wr_flags  = reg_wr && (reg_addr == A_FLAGS);
  assign wr_enable = reg_wr && (reg_addr == A_ENABLE);

  irq_w1c_bank #(.W(REG_W), .KEEP(ST_STICKY_MASK)) u_status (
    .clk(clk), .rst(rst), .evt(st_evt),
    .clr_en(wr_status), .clr_data(reg_wdata), .q(st_q));

  irq_cfg_reg #(.W(REG_W), .KEEP(ST_STICKY_MASK)) u_errmask (
    .clk(clk), .rst(rst), .wr(wr_mask), .wdata(reg_wdata), .q(mask_q));

  irq_w1c_bank #(.W(REG_W), .KEEP(FL_STICKY_MASK)) u_flags (
    .clk(clk), .rst(rst), .evt(fl_evt),
    .clr_en(wr_flags), .clr_data(reg_wdata), .q(fl_q));

  irq_cfg_reg #(.W(REG_W), .KEEP(FL_GATED_MASK)) u_enable (
    .clk(clk), .rst(rst), .wr(wr_enable), .wdata(reg_wdata), .q(en_q));

  // controller line mirror
  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 1'b0;
    else     ctrl_q <= ctrl_irq;
  end

  // first-level roll-up
  assign spi_sum = |(st_q & ~mask_q);
  assign int_sum = |(st_q & ST_INTERNAL_MASK);

  // second-level roll-up
  assign pending = (|(fl_q & en_q & FL_GATED_MASK)) | (|(fl_q & FL_NMI_MASK))
                 | spi_sum | ctrl_q;

  always_comb begin
    st_view = st_q;
    st_view[ST_PEND_BIT] = pending;
    st_view[ST_SPI_BIT]  = spi_sum;
    st_view[ST_INT_BIT]  = int_sum;
    fl_view = fl_q;
    fl_view[FL_SPIERR_BIT] = spi_sum;
    fl_view[FL_CTRL_BIT]   = ctrl_q;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_STATUS)  rd_mux = st_view;
    if (reg_addr == A_ERRMASK) rd_mux = mask_q;
    if (reg_addr == A_FLAGS)   rd_mux = fl_view;
    if (reg_addr == A_ENABLE)  rd_mux = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      gstat_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      rdata_q <= rd_mux;
      gstat_q <= fl_view[GSTAT_W-1:0];
      irq_n_q <= ~pending;
    end
  end

  assign reg_rdata = rdata_q;
  assign gstat     = gstat_q;
  assign irq_n     = irq_n_q;

  AST_CTRL_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!rst && ctrl_q) |=> !irq_n); // R10
  AST_SPI_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!rst && spi_sum) |=> !irq_n); // R10
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!rst && fl_q == '0 && !spi_sum && !ctrl_q) |=> irq_n); // R11
  AST_GSTAT_CTRL: assert property (@(posedge clk) disable iff (rst)
    (!rst && ctrl_q) |=> gstat[FL_CTRL_BIT]); // R12
endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] st_evt = '0;
  logic [31:0] fl_evt = '0;
  logic        ctrl_irq = 1'b0;
  logic [7:0]  gstat;
  logic        irq_n;
  int total = 0;
  int bad = 0;

  localparam logic [7:0] A_ST = 8'h00, A_MK = 8'h04, A_FL = 8'h08, A_EN = 8'h0C;

  always #5 clk = ~clk;

  irq_agg_top #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_evt(st_evt),
    .fl_evt(fl_evt), .ctrl_irq(ctrl_irq), .gstat(gstat), .irq_n(irq_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk) reg_addr = a;
    @(negedge clk) v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic pulse_st(input logic [31:0] m);
    @(negedge clk) st_evt = m;
    @(negedge clk) st_evt = '0;
  endtask

  task automatic pulse_fl(input logic [31:0] m);
    @(negedge clk) fl_evt = m;
    @(negedge clk) fl_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, v); check("R1 status", v, 0);
    rd(A_MK, v); check("R1 mask", v, 0);
    rd(A_FL, v); check("R1 flags", v, 0);
    rd(A_EN, v); check("R1 enable", v, 0);
    check("R1 irq_n", 32'(irq_n), 1);
    check("R1 gstat", 32'(gstat), 0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    pulse_st(32'hFFFF_FFFF);
    check("R11 irq_n not yet low", 32'(irq_n), 1);
    @(negedge clk) check("R11 irq_n low", 32'(irq_n), 0);
    rd(A_ST, v); check("R2 R8 status all set", v, 32'h3F3F_0007);
    rd(A_FL, v); check("R6 flag bit3 summary", v, 32'h0000_0008);
    check("R12 gstat spierr", 32'(gstat), 32'h08);
    wr(A_ST, 32'h0100_0000);
    rd(A_ST, v); check("R3 clear one bit", v, 32'h3E3F_0007);
    wr(A_ST, 32'h0000_0000);
    rd(A_ST, v); check("R3 zero write keeps", v, 32'h3E3F_0007);
    wr(A_ST, 32'hFFFF_FFFF);
    check("R11 irq_n held one cycle", 32'(irq_n), 0);
    @(negedge clk) check("R11 irq_n released", 32'(irq_n), 1);
    rd(A_ST, v); check("R3 all cleared", v, 0);
    pulse_st(32'h0800_0000);
    rd(A_ST, v); check("R8 internal summary", v, 32'h0800_0007);
    wr(A_ST, 32'h0800_0000);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    pulse_st(32'h0001_0000);
    wr(A_MK, 32'h0001_0000);
    rd(A_ST, v); check("R6 masked bit no summary", v, 32'h0001_0000);
    check("R6 masked irq_n", 32'(irq_n), 1);
    wr(A_MK, 32'hFFFF_FFFF);
    rd(A_MK, v); check("R6 mask readback", v, 32'h3F3F_0000);
    wr(A_MK, 32'h0);
    rd(A_ST, v); check("R6 unmasked summary", v, 32'h0001_0003);
    wr(A_FL, 32'h0000_000A);
    rd(A_FL, v); check("R6 derived bits ignore write", v, 32'h0000_0008);
    wr(A_ST, 32'h0001_0000);
    rd(A_ST, v); check("R3 status empty", v, 0);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    pulse_fl(32'hFFFF_FFFF);
    rd(A_FL, v); check("R4 flags set", v, 32'h00FD_E500);
    check("R10 nonmaskable irq", 32'(irq_n), 0);
    wr(A_FL, 32'h00FD_E500);
    rd(A_FL, v); check("R4 flags cleared", v, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); check("R9 enable readback", v, 32'h0069_C500);
    wr(A_EN, 32'h0);
    pulse_fl(32'h0040_0000);
    @(negedge clk);
    check("R9 disabled flag no irq", 32'(irq_n), 1);
    wr(A_EN, 32'h0040_0000);
    check("R11 enable one cycle", 32'(irq_n), 1);
    @(negedge clk) check("R9 enabled flag irq", 32'(irq_n), 0);
    wr(A_FL, 32'h0040_0000);
    check("R11 release held", 32'(irq_n), 0);
    @(negedge clk) check("R11 release", 32'(irq_n), 1);
    wr(A_EN, 32'h0);
    pulse_fl(32'h0010_0000);
    @(negedge clk) check("R10 bit20 irq without enable", 32'(irq_n), 0);
    wr(A_FL, 32'h0010_0000);
    @(negedge clk) check("R10 bit20 cleared", 32'(irq_n), 1);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    @(negedge clk) ctrl_irq = 1'b1;
    @(negedge clk) check("R11 ctrl not yet", 32'(irq_n), 1);
    @(negedge clk) check("R10 ctrl irq", 32'(irq_n), 0);
    rd(A_FL, v); check("R7 ctrl mirror", v, 32'h2);
    check("R12 gstat ctrl", 32'(gstat), 32'h02);
    wr(A_FL, 32'h2);
    rd(A_FL, v); check("R7 mirror ignores write", v, 32'h2);
    @(negedge clk) ctrl_irq = 1'b0;
    @(negedge clk);
    @(negedge clk) check("R7 R11 ctrl gone", 32'(irq_n), 1);
    rd(A_FL, v); check("R7 mirror low", v, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pulse_fl(32'h0000_0100);
    @(negedge clk) begin
      fl_evt = 32'h100; reg_wr = 1'b1; reg_addr = A_FL; reg_wdata = 32'h100;
    end
    @(negedge clk) begin fl_evt = '0; reg_wr = 1'b0; end
    rd(A_FL, v); check("R5 flag event wins", v, 32'h100);
    wr(A_FL, 32'h100);
    rd(A_FL, v); check("R5 flag later clear", v, 0);
    pulse_st(32'h0002_0000);
    @(negedge clk) begin
      st_evt = 32'h2_0000; reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h2_0000;
    end
    @(negedge clk) begin st_evt = '0; reg_wr = 1'b0; end
    rd(A_ST, v); check("R5 status event wins", v, 32'h0002_0003);
    wr(A_ST, 32'h2_0000);
    rd(A_ST, v); check("R5 status later clear", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R13 unmapped reads zero", v, 0);
    rd(A_EN, v); check("R13 enable untouched", v, 0);
    rd(A_MK, v); check("R13 mask untouched", v, 0);
    rd(A_ST, v); check("R13 status untouched", v, 0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_status();
    t_mask();
    t_flags();
    t_enable();
    t_ctrl();
    t_race();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule